// File: doc/BRIEF.md
# Critical-Beat Read Line Buffer

This block services processor reads aimed at PCI address space. A read is accepted on the processor side and turned into a four-beat line fetch on the PCI master side. The beats are always fetched in ascending order starting at beat 0, and each beat is stored in its own slot. Once the whole line is held, the processor receives it starting at the beat it asked for first, then wrapping around through the rest of the line.

Two conditions from the PCI side can delay completion. The first is a PCI target disconnect partway through the line. If another PCI master then begins an access to local memory, the processor transaction is sent a retry so that the snoop for that access can run. The fetch then resumes from the first missing beat. When the processor re-presents the same address, the held line is served without fetching it again. The second condition is an outstanding snoop for a PCI write to local memory, which blocks the release of data to the processor. For as long as a complete line sits undelivered, the block asks the PCI side to retry every new write to local memory.

Top module: `crit_line_rdbuf`

## Requirements
- R1: The PCI fetch for a new read starts at beat 0 and continues in ascending order. `pci_beat` always shows the index of the next beat to be stored, and `pci_req` is high only while the line is incomplete.
- R2: The processor receives beat c, c+1, c+2, c+3 (modulo 4). Here c is `cpu_addr[4:3]`, and beat b occupies byte offsets b*8 to b*8+7 of the line.
- R3: `cpu_aack` pulses high for exactly one cycle, and only after all four beats are stored. It is high in the same cycle as the first data beat.
- R4: A PCI disconnect before the line is complete, followed by `pci_lm_access` before the next beat arrives, gives a one-cycle `cpu_retry` and no `cpu_aack` for that address phase.
- R5: After a disconnect the fetch resumes at the first missing beat. A re-presented read with the same address is served from the held beats, with no new PCI request once the line is complete.
- R6: `cpu_dvalid` is never high while `snoop_busy` is high, and `cpu_aack` is not given while it is high.
- R7: `lm_wr_retry` is high from the cycle after the fourth beat is stored until the last beat is accepted by the processor, and low otherwise.
- R8: `pci_lm_access` has no effect if no disconnect preceded it, or if the line is already complete. In those cases no `cpu_retry` is given.
- R9: `cpu_data` is stable while `cpu_dvalid` is high and `cpu_dready` is low. `cpu_dlast` marks the fourth beat, and after it is accepted the block is idle with `pci_req`, `cpu_dvalid` and `lm_wr_retry` low.
- R10: After reset, `cpu_aack`, `cpu_retry`, `cpu_dvalid`, `pci_req` and `lm_wr_retry` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor read address phase valid |
| cpu_addr | input | ADDR_W | Processor byte address; bits [4:3] give the critical beat |
| cpu_aack | output | 1 | Address phase ended, data follows |
| cpu_retry | output | 1 | Address phase retried; processor must re-present |
| cpu_dvalid | output | 1 | Data beat valid |
| cpu_dready | input | 1 | Processor accepts the data beat |
| cpu_data | output | DATA_W | Data beat |
| cpu_dlast | output | 1 | Current beat is the last of the line |
| pci_req | output | 1 | Request for further line beats |
| pci_addr | output | ADDR_W | Byte address of the next beat wanted |
| pci_beat | output | IDX_W | Index of the next beat wanted |
| pci_dvalid | input | 1 | A line beat is delivered |
| pci_data | input | DATA_W | Line beat data |
| pci_disc | input | 1 | Target disconnect ends the current burst |
| pci_lm_access | input | 1 | Another PCI master started a local-memory access |
| snoop_busy | input | 1 | A snoop for a PCI write to local memory is outstanding |
| lm_wr_retry | output | 1 | PCI side must retry new writes to local memory |

## Verification
The hardest state to reach is a partial line, cut off by a disconnect, that is then interrupted by a local-memory access. It must survive a retry and be completed under two separate orders of events. The bench cuts the burst at each beat position and raises the alternate-master access in the cycle after the cut. It then either lets the fetch finish before the processor returns, or brings the processor back at once so the fetch finishes inside the resumed transaction. A stall on outstanding snoops is applied both before the first beat and in the middle of delivery.

// File: rtl/crb_pkg.sv
package crb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT_SNOOP,
        ST_DELIVER,
        ST_RETRY_PENDING
    } crb_state_e;
endpackage

// File: rtl/crb_fill_track.sv
// Tracks which beats of the line are held; beats arrive in ascending order
module crb_fill_track #(
    parameter int BEATS = 4,
    parameter int IDX_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr,
    output logic [IDX_W-1:0] next_idx,
    output logic             full
);
    typedef struct packed {
        logic [BEATS-1:0] mask;
    } fill_t;

    fill_t fill_d, fill_q;

    always_comb begin
        next_idx = '0;
        for (int i = BEATS - 1; i >= 0; i--) begin
            if (!fill_q.mask[i]) next_idx = IDX_W'(i);
        end
        full = &fill_q.mask;

        fill_d = fill_q;
        if (clear) begin
            fill_d.mask = '0;
        end else if (wr && !full) begin
            fill_d.mask[next_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fill_q <= '0;
        else        fill_q <= fill_d;
    end
endmodule

// File: rtl/crb_beat_store.sv
// One register per beat, written by index, read by index
module crb_beat_store #(
    parameter int BEATS  = 4,
    parameter int IDX_W  = $clog2(BEATS),
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] slot_q [BEATS];

    for (genvar g = 0; g < BEATS; g++) begin : g_slot
        logic [DATA_W-1:0] slot_d;

        always_comb begin
            slot_d = slot_q[g];
            if (wr && (widx == IDX_W'(g))) slot_d = wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d;
        end
    end

    assign rdata = slot_q[ridx];
endmodule

// File: rtl/crb_wrap_seq.sv
// Steps the delivery offset; read index wraps from the critical beat
module crb_wrap_seq #(
    parameter int BEATS = 4,
    parameter int IDX_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             adv,
    input  logic [IDX_W-1:0] crit,
    output logic [IDX_W-1:0] ridx,
    output logic             last
);
    typedef struct packed {
        logic [IDX_W-1:0] ofs;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!run)     seq_d.ofs = '0;
        else if (adv) seq_d.ofs = seq_q.ofs + 1'b1;
        ridx = crit + seq_q.ofs;
        last = (seq_q.ofs == IDX_W'(BEATS - 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end
endmodule

// File: rtl/crb_ctrl.sv
// Transaction control: fetch, retry on disconnect, snoop hold, delivery
module crb_ctrl
    import crb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 2,
    parameter int BOFF    = 3,
    localparam int LINE_LSB = BOFF + IDX_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_req,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic                     full,
    input  logic                     pci_dvalid,
    input  logic                     pci_disc,
    input  logic                     pci_lm_access,
    input  logic                     snoop_busy,
    input  logic                     done,
    output crb_state_e               state,
    output logic [ADDR_W-LINE_LSB-1:0] line,
    output logic [IDX_W-1:0]         crit,
    output logic                     aack,
    output logic                     retry
);
    typedef struct packed {
        crb_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic              broken;
        logic              aack;
        logic              retry;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.aack  = 1'b0;
        c_d.retry = 1'b0;

        if (pci_disc)        c_d.broken = 1'b1;
        else if (pci_dvalid) c_d.broken = 1'b0;

        unique case (c_q.state)
            ST_IDLE: begin
                c_d.broken = 1'b0;
                if (cpu_req) begin
                    c_d.addr  = cpu_addr;
                    c_d.state = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (full) begin
                    c_d.state = ST_WAIT_SNOOP;
                end else if (c_q.broken && pci_lm_access) begin
                    c_d.retry = 1'b1;
                    c_d.state = ST_RETRY_PENDING;
                end
            end
            ST_RETRY_PENDING: begin
                if (!c_q.retry && cpu_req && (cpu_addr == c_q.addr)) begin
                    c_d.broken = 1'b0;
                    c_d.state  = full ? ST_WAIT_SNOOP : ST_FETCH;
                end
            end
            ST_WAIT_SNOOP: begin
                if (!snoop_busy) begin
                    c_d.aack  = 1'b1;
                    c_d.state = ST_DELIVER;
                end
            end
            ST_DELIVER: begin
                if (done) c_d.state = ST_IDLE;
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign state = c_q.state;
    assign line  = c_q.addr[ADDR_W-1:LINE_LSB];
    assign crit  = c_q.addr[LINE_LSB-1:BOFF];
    assign aack  = c_q.aack;
    assign retry = c_q.retry;
endmodule

// File: rtl/crit_line_rdbuf.sv
module crit_line_rdbuf
    import crb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int BEATS  = 4,
    localparam int IDX_W    = $clog2(BEATS),
    localparam int BOFF     = $clog2(DATA_W / 8),
    localparam int LINE_LSB = BOFF + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_aack,
    output logic              cpu_retry,
    output logic              cpu_dvalid,
    input  logic              cpu_dready,
    output logic [DATA_W-1:0] cpu_data,
    output logic              cpu_dlast,
    output logic              pci_req,
    output logic [ADDR_W-1:0] pci_addr,
    output logic [IDX_W-1:0]  pci_beat,
    input  logic              pci_dvalid,
    input  logic [DATA_W-1:0] pci_data,
    input  logic              pci_disc,
    input  logic              pci_lm_access,
    input  logic              snoop_busy,
    output logic              lm_wr_retry
);
    crb_state_e                 state;
    logic [ADDR_W-LINE_LSB-1:0] line;
    logic [IDX_W-1:0]           crit;
    logic [IDX_W-1:0]           next_idx;
    logic [IDX_W-1:0]           ridx;
    logic                       full, last, wr, done, fetching;

    assign fetching    = (state == ST_FETCH) || (state == ST_RETRY_PENDING);
    assign pci_req     = fetching && !full;
    assign wr          = pci_req && pci_dvalid;
    assign pci_beat    = next_idx;
    assign pci_addr    = {line, next_idx, {BOFF{1'b0}}};
    assign cpu_dvalid  = (state == ST_DELIVER) && !snoop_busy;
    assign cpu_dlast   = cpu_dvalid && last;
    assign done        = cpu_dvalid && cpu_dready && last;
    assign lm_wr_retry = full && (state != ST_IDLE);

    crb_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BOFF(BOFF)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .full(full), .pci_dvalid(pci_dvalid), .pci_disc(pci_disc),
        .pci_lm_access(pci_lm_access), .snoop_busy(snoop_busy), .done(done),
        .state(state), .line(line), .crit(crit),
        .aack(cpu_aack), .retry(cpu_retry)
    );

    crb_fill_track #(.BEATS(BEATS), .IDX_W(IDX_W)) u_fill (
        .clk(clk), .rst_n(rst_n),
        .clear(state == ST_IDLE), .wr(wr),
        .next_idx(next_idx), .full(full)
    );

    crb_beat_store #(.BEATS(BEATS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr(wr), .widx(next_idx), .wdata(pci_data),
        .ridx(ridx), .rdata(cpu_data)
    );

    crb_wrap_seq #(.BEATS(BEATS), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .run(state == ST_DELIVER), .adv(cpu_dvalid && cpu_dready),
        .crit(crit), .ridx(ridx), .last(last)
    );
endmodule

// File: rtl/crb_chk.sv
module crb_chk #(
    parameter int DATA_W = 64,
    parameter int BEATS  = 4,
    localparam int IDX_W = $clog2(BEATS),
    localparam int CW    = $clog2(BEATS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_aack,
    input logic              cpu_retry,
    input logic              cpu_dvalid,
    input logic              cpu_dready,
    input logic [DATA_W-1:0] cpu_data,
    input logic              cpu_dlast,
    input logic              pci_req,
    input logic [IDX_W-1:0]  pci_beat,
    input logic              pci_dvalid,
    input logic              snoop_busy,
    input logic              lm_wr_retry
);
    logic [CW-1:0] got_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                                 got_q <= '0;
        else if (cpu_dvalid && cpu_dready && cpu_dlast) got_q <= '0;
        else if (pci_req && pci_dvalid)             got_q <= got_q + 1'b1;
    end

    a_r1_req_incomplete: assert property (@(posedge clk) disable iff (!rst_n)
        pci_req |-> (got_q < CW'(BEATS)));
    a_r1_ascending_beat: assert property (@(posedge clk) disable iff (!rst_n)
        pci_req |-> (pci_beat == got_q[IDX_W-1:0]));
    a_r3_aack_line_full: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_aack |-> (got_q == CW'(BEATS)));
    a_r3_aack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_aack |=> !cpu_aack);
    a_r4_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_aack && cpu_retry));
    a_r6_snoop_gate: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_busy |-> !cpu_dvalid);
    a_r7_lmret_with_data: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_dvalid |-> lm_wr_retry);
    a_r7_lmret_full_only: assert property (@(posedge clk) disable iff (!rst_n)
        lm_wr_retry |-> (got_q == CW'(BEATS)));
    a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_dvalid && !cpu_dready) |=> (!cpu_dvalid || $stable(cpu_data)));
endmodule

bind crit_line_rdbuf crb_chk #(.DATA_W(DATA_W), .BEATS(BEATS)) u_crb_chk (
    .clk(clk), .rst_n(rst_n),
    .cpu_aack(cpu_aack), .cpu_retry(cpu_retry),
    .cpu_dvalid(cpu_dvalid), .cpu_dready(cpu_dready),
    .cpu_data(cpu_data), .cpu_dlast(cpu_dlast),
    .pci_req(pci_req), .pci_beat(pci_beat), .pci_dvalid(pci_dvalid),
    .snoop_busy(snoop_busy), .lm_wr_retry(lm_wr_retry)
);

// File: tb/crit_line_rdbuf_test.sv
module crit_line_rdbuf_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 64;
    localparam int WD_CYCLES = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic              cpu_aack, cpu_retry, cpu_dvalid, cpu_dlast;
    logic              cpu_dready = 1'b0;
    logic [DATA_W-1:0] cpu_data;
    logic              pci_req;
    logic [ADDR_W-1:0] pci_addr;
    logic [1:0]        pci_beat;
    logic              pci_dvalid = 1'b0;
    logic [DATA_W-1:0] pci_data = '0;
    logic              pci_disc = 1'b0;
    logic              pci_lm_access = 1'b0;
    logic              snoop_busy = 1'b0;
    logic              lm_wr_retry;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    crit_line_rdbuf uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_aack(cpu_aack), .cpu_retry(cpu_retry),
        .cpu_dvalid(cpu_dvalid), .cpu_dready(cpu_dready),
        .cpu_data(cpu_data), .cpu_dlast(cpu_dlast),
        .pci_req(pci_req), .pci_addr(pci_addr), .pci_beat(pci_beat),
        .pci_dvalid(pci_dvalid), .pci_data(pci_data), .pci_disc(pci_disc),
        .pci_lm_access(pci_lm_access), .snoop_busy(snoop_busy),
        .lm_wr_retry(lm_wr_retry)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(input int line, input int crit);
        return (ADDR_W'(line) << 5) | (ADDR_W'(crit) << 3);
    endfunction

    function automatic logic [DATA_W-1:0] pat(input int line, input int b);
        return {32'(line), 24'hB0B0B0, 8'(b)};
    endfunction

    task automatic present(input int line, input int crit);
        @(negedge clk);
        cpu_req  = 1'b1;
        cpu_addr = mk_addr(line, crit);
        @(posedge clk);
    endtask

    task automatic feed(input int line, input int first, input int last_b,
                        input int disc_at, input bit lm_noise);
        for (int b = first; b <= last_b; b++) begin
            @(negedge clk);
            pci_dvalid    = 1'b1;
            pci_data      = pat(line, b);
            pci_disc      = (b == disc_at);
            pci_lm_access = lm_noise;
            #1;
            chk("R1 pci_req during fetch", pci_req, 1);
            chk("R1 pci_beat order", pci_beat, b);
            chk("R3 no aack before full", cpu_aack, 0);
            if (lm_noise) chk("R8 no retry without disconnect", cpu_retry, 0);
            @(posedge clk);
        end
        #1;
        pci_dvalid = 1'b0; pci_disc = 1'b0; pci_lm_access = 1'b0;
    endtask

    task automatic wait_aack(input string tag, output bit saw_retry);
        bit got = 1'b0;
        saw_retry = 1'b0;
        for (int i = 0; i < 20 && !got; i++) begin
            @(negedge clk);
            #1;
            if (cpu_retry) saw_retry = 1'b1;
            if (cpu_aack) got = 1'b1;
        end
        chk(tag, got, 1);
    endtask

    // stall_kind: 0 none, 1 snoop outstanding, 2 processor not ready
    task automatic deliver(input int line, input int crit, input int stall_k, input int stall_kind);
        for (int k = 0; k < 4; k++) begin
            if (k > 0) @(negedge clk);
            cpu_req    = 1'b0;
            cpu_dready = 1'b1;
            if (k == stall_k && stall_kind != 0) begin
                for (int s = 0; s < 2; s++) begin
                    if (stall_kind == 1) snoop_busy = 1'b1;
                    else                 cpu_dready = 1'b0;
                    #1;
                    if (stall_kind == 1) begin
                        chk("R6 no data while snoop busy", cpu_dvalid, 0);
                    end else begin
                        chk("R9 valid held while not ready", cpu_dvalid, 1);
                        chk("R9 data stable while not ready", cpu_data, pat(line, (crit + k) % 4));
                    end
                    @(posedge clk);
                    @(negedge clk);
                end
                snoop_busy = 1'b0;
                cpu_dready = 1'b1;
            end
            #1;
            chk("R2 beat valid", cpu_dvalid, 1);
            chk("R2 wrap order data", cpu_data, pat(line, (crit + k) % 4));
            chk("R9 last marker", cpu_dlast, (k == 3));
            chk("R7 write retry during delivery", lm_wr_retry, 1);
            @(posedge clk);
        end
        #1;
        cpu_dready = 1'b0;
        @(negedge clk);
        #1;
        chk("R7 write retry dropped", lm_wr_retry, 0);
        chk("R9 idle no data", cpu_dvalid, 0);
        chk("R9 idle no pci request", pci_req, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R10 reset aack", cpu_aack, 0);
        chk("R10 reset retry", cpu_retry, 0);
        chk("R10 reset dvalid", cpu_dvalid, 0);
        chk("R10 reset pci_req", pci_req, 0);
        chk("R10 reset lm_wr_retry", lm_wr_retry, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_plain(input int line, input int crit, input bit lm_noise,
                           input int stall_k, input int stall_kind);
        bit saw;
        present(line, crit);
        feed(line, 0, 3, -1, lm_noise);
        @(negedge clk);
        #1;
        chk("R7 write retry once full", lm_wr_retry, 1);
        chk("R3 no aack in full cycle", cpu_aack, 0);
        wait_aack("R3 aack after full line", saw);
        chk("R8 no retry on plain read", saw, 0);
        deliver(line, crit, stall_k, stall_kind);
    endtask

    task automatic t_disc(input int line, input int crit, input int p, input bit early);
        bit saw;
        present(line, crit);
        feed(line, 0, p, p, 1'b0);
        @(negedge clk);
        pci_lm_access = 1'b1;
        @(posedge clk);
        #1;
        pci_lm_access = 1'b0;
        if (p < 3) begin
            @(negedge clk);
            #1;
            chk("R4 retry after disconnect and access", cpu_retry, 1);
            chk("R4 no aack with retry", cpu_aack, 0);
            cpu_req = 1'b0;
            @(negedge clk);
            #1;
            chk("R4 retry is one cycle", cpu_retry, 0);
            if (early) begin
                present(line, crit);
                feed(line, p + 1, 3, -1, 1'b0);
            end else begin
                feed(line, p + 1, 3, -1, 1'b0);
                @(negedge clk);
                #1;
                chk("R7 write retry while line parked", lm_wr_retry, 1);
                chk("R5 no aack before re-present", cpu_aack, 0);
                present(line, crit);
                @(negedge clk);
                #1;
                chk("R5 no refetch after re-present", pci_req, 0);
            end
            wait_aack("R5 aack on re-presented read", saw);
            chk("R5 no second retry", saw, 0);
        end else begin
            wait_aack("R8 aack despite late access", saw);
            chk("R8 full line ignores access", saw, 0);
        end
        deliver(line, crit, -1, 0);
    endtask

    task automatic t_snoop(input int line, input int crit);
        bit saw;
        snoop_busy = 1'b1;
        present(line, crit);
        feed(line, 0, 3, -1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            chk("R6 no aack while snoop busy", cpu_aack, 0);
            chk("R6 no data while snoop busy", cpu_dvalid, 0);
            chk("R7 write retry while held", lm_wr_retry, 1);
        end
        @(negedge clk);
        snoop_busy = 1'b0;
        wait_aack("R6 aack after snoop clears", saw);
        deliver(line, crit, 1, 1);
    endtask

    initial begin
        t_reset();
        for (int c = 0; c < 4; c++) t_plain(16 + c, c, 1'b0, -1, 0);
        t_plain(30, 1, 1'b1, -1, 0);
        t_plain(31, 3, 1'b0, 2, 2);
        for (int p = 0; p < 4; p++) t_disc(40 + p, (p + 1) % 4, p, 1'b0);
        t_disc(50, 2, 1, 1'b1);
        t_disc(51, 0, 0, 1'b1);
        t_snoop(60, 2);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= WD_CYCLES) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WD_CYCLES);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule